// File: doc/BRIEF.md
# PHY Link Configuration Sequencer

This block brings an Ethernet PHY up after power-on and settles the speed and duplex mode that the MAC must use. It drives a register access port that sits in front of a separate management serial engine. Each access is a request that stays raised until the engine acknowledges it. When asked, the block first looks for a PHY by probing every management address in turn. It then takes the PHY through a soft reset. Next it either reads the forced configuration or waits for autonegotiation, and it resolves the common mode from the local advertisement registers and the link partner ability registers.

A single pulse on `start` launches the whole sequence. At the end the block raises either `link_done`, with the gigabit, 100 Mb/s and full-duplex flags valid, or `link_fail` if the PHY never leaves reset within the timeout. A management read flagged as invalid is treated as all ones. All of the sequence's time limits come from one millisecond window that is derived from the clock frequency parameter.

Top module: `phy_link_seq`

## Requirements
- R1: Between runs no request is raised. A `start` pulse begins a run. With `scan_en` set, register 0 is read at addresses 0, 1, 2 and so on up to 31, and the first address whose value is neither 0x0000 nor 0xFFFF becomes `phy_addr`. If no address qualifies, or scanning is off, `default_addr` is used.
- R2: Register 0 at the chosen address is polled until bit 15 reads 0. That value is written back to register 0 with bit 15 set. Register 0 is then polled again until bit 15 reads 0. Only register 0 is ever written.
- R3: One window of TIMEOUT_MS milliseconds opens when the first reset poll begins. If a reset poll still sees bit 15 set after the window has expired, the run ends with a one-cycle `link_fail`, and all mode flags are 0.
- R4: If register 0 bit 12 (autonegotiation enable) reads 0 after reset, 0x0000 is written to register 0 and the run finishes with all mode flags at 0.
- R5: If autonegotiation is enabled, register 1 is polled until bit 5 is set. If the window expires first, register 0 is read once more and the result is gigabit = bit6 AND NOT bit13, 100M = NOT bit6 AND bit13, full = bit8.
- R6: If register 1 bit 8 is set, register 9 and then register 10 are read. Gigabit full duplex applies when reg9 bit 9 and reg10 bit 11 are both set. Gigabit half duplex applies when reg9 bit 8 and reg10 bit 10 are both set. They are applied in that order, so the later match wins.
- R7: If gigabit was not resolved, or `mac_gbit_ok` is 0, register 4 and then register 5 are read. Three matches are applied in order, each when the bit is set in both registers: bit 8 sets 100M and full, bit 7 sets 100M and clears full, and bit 6 sets full.
- R8: If gigabit was resolved while `mac_gbit_ok` is 0, gigabit and full are cleared and register 0 is written with the 100M flag at bit 13 and all other bits 0.
- R9: A read returned with `mgmt_rinv` set is handled as the value 0xFFFF.
- R10: `link_done` lasts one cycle, in the same cycle that the mode flags take their result. The flags are cleared by `start` and otherwise hold. Gigabit and 100M are never both set. While `mgmt_req` waits for `mgmt_ack`, the request fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run (taken while idle) |
| scan_en | input | 1 | Probe addresses 0..31 before configuring |
| default_addr | input | 5 | PHY address used when scanning is off or finds nothing |
| mac_gbit_ok | input | 1 | MAC supports gigabit operation |
| mgmt_req | output | 1 | Management access request, held until acknowledged |
| mgmt_wr | output | 1 | 1 = write, 0 = read |
| mgmt_phy | output | 5 | PHY address of the access |
| mgmt_reg | output | 5 | Register number of the access |
| mgmt_wdata | output | 16 | Write data |
| mgmt_ack | input | 1 | One-cycle completion of the current access |
| mgmt_rdata | input | 16 | Read data, valid with `mgmt_ack` |
| mgmt_rinv | input | 1 | Read data invalid, valid with `mgmt_ack` |
| phy_addr | output | 5 | Address selected for the PHY |
| mode_gbit | output | 1 | Resolved 1000 Mb/s |
| mode_100 | output | 1 | Resolved 100 Mb/s |
| mode_full | output | 1 | Resolved full duplex |
| link_done | output | 1 | One-cycle pulse: run finished, flags valid |
| link_fail | output | 1 | One-cycle pulse: PHY reset timed out |

## Verification
A corrupted sequencer state shows up on the management port at the very next acknowledged access. The wrong register, address or write value appears there, or a branch is skipped, and the bench compares every access with its expected order. A wrong captured ability bit stays hidden until the end of the run, and it then appears as a wrong flag in the cycle of `link_done`. A broken timeout counter shows as a `link_fail` that comes outside the expected window, or as a fallback read that never comes.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int PA_W = 5;
  localparam int RA_W = 5;
  localparam int D_W  = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_POLL_PRE, S_RST_WR, S_POLL_POST, S_AN_OFF,
    S_AN_POLL, S_FALLBACK, S_RD_ADV1G, S_RD_LP1G, S_RD_ADV, S_RD_LP,
    S_DECIDE, S_DOWN_WR, S_FINISH, S_FAIL
  } seq_state_t;

  localparam logic [RA_W-1:0] REG_CTRL  = 5'd0;
  localparam logic [RA_W-1:0] REG_STAT  = 5'd1;
  localparam logic [RA_W-1:0] REG_ADV   = 5'd4;
  localparam logic [RA_W-1:0] REG_LP    = 5'd5;
  localparam logic [RA_W-1:0] REG_ADV1G = 5'd9;
  localparam logic [RA_W-1:0] REG_LP1G  = 5'd10;

  // control register bits
  localparam int B_RESET  = 15;
  localparam int B_SEL_HI = 13;
  localparam int B_AN_EN  = 12;
  localparam int B_DUPLEX = 8;
  localparam int B_SEL_LO = 6;
  // status register bits
  localparam int B_AN_DONE = 5;
  localparam int B_EXT_ST  = 8;
endpackage

// File: rtl/phy_ms_timer.sv
module phy_ms_timer #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TIMEOUT_MS = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CYC_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int PW = $clog2(CYC_PER_MS + 1);
  localparam int MW = $clog2(TIMEOUT_MS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_MS - 1);
  localparam logic [MW-1:0] MS_LIM   = MW'(TIMEOUT_MS);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (ms_q != MS_LIM) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        ms_q  <= ms_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expired = (ms_q == MS_LIM);
endmodule

// File: rtl/phy_mode_resolve.sv
module phy_mode_resolve (
  input  logic [1:0] adv1g,    // {1000 full, 1000 half} advertised
  input  logic [1:0] lp1g,     // {1000 full, 1000 half} partner
  input  logic [2:0] adv,      // {100 full, 100 half, 10 full} advertised
  input  logic [2:0] lp,       // same, partner
  input  logic       mac_gbit_ok,
  output logic       need_low,
  output logic       downgrade,
  output logic       gb,
  output logic       sp,
  output logic       fd
);
  logic g, f, s;

  always_comb begin
    g = 1'b0;
    f = 1'b0;
    s = 1'b0;
    if (adv1g[1] && lp1g[1]) begin g = 1'b1; f = 1'b1; end
    if (adv1g[0] && lp1g[0]) begin g = 1'b1; f = 1'b0; end
    need_low = !g || !mac_gbit_ok;
    if (need_low) begin
      if (adv[2] && lp[2]) begin s = 1'b1; f = 1'b1; end
      if (adv[1] && lp[1]) begin s = 1'b1; f = 1'b0; end
      if (adv[0] && lp[0]) f = 1'b1;
    end
    downgrade = g && !mac_gbit_ok;
    gb = g && mac_gbit_ok;
    sp = s;
    fd = downgrade ? 1'b0 : f;
  end
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_seq_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TIMEOUT_MS = 3000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            scan_en,
  input  logic [PA_W-1:0] default_addr,
  input  logic            mac_gbit_ok,
  output logic            mgmt_req,
  output logic            mgmt_wr,
  output logic [PA_W-1:0] mgmt_phy,
  output logic [RA_W-1:0] mgmt_reg,
  output logic [D_W-1:0]  mgmt_wdata,
  input  logic            mgmt_ack,
  input  logic [D_W-1:0]  mgmt_rdata,
  input  logic            mgmt_rinv,
  output logic [PA_W-1:0] phy_addr,
  output logic            mode_gbit,
  output logic            mode_100,
  output logic            mode_full,
  output logic            link_done,
  output logic            link_fail
);
  localparam logic [PA_W-1:0] LAST_ADDR = {PA_W{1'b1}};

  seq_state_t      state;
  logic [PA_W-1:0] scan_idx;
  logic [D_W-1:0]  r0_q;
  logic [1:0]      adv1g_q, lp1g_q;
  logic [2:0]      adv_q, lp_q;
  logic            have_low;
  logic            res_gb, res_sp, res_fd;
  logic [D_W-1:0]  d;
  logic            run, expired;
  logic            need_low, downgrade, rs_gb, rs_sp, rs_fd;

  assign d   = mgmt_rinv ? {D_W{1'b1}} : mgmt_rdata;
  assign run = !(state inside {S_IDLE, S_SCAN, S_FINISH, S_FAIL});

  phy_ms_timer #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TIMEOUT_MS)) u_tmr (
    .clk(clk), .rst(rst), .run(run), .expired(expired)
  );

  phy_mode_resolve u_res (
    .adv1g(adv1g_q), .lp1g(lp1g_q), .adv(adv_q), .lp(lp_q),
    .mac_gbit_ok(mac_gbit_ok), .need_low(need_low), .downgrade(downgrade),
    .gb(rs_gb), .sp(rs_sp), .fd(rs_fd)
  );

  // request fields decode straight from the state register
  always_comb begin
    mgmt_req   = 1'b1;
    mgmt_wr    = 1'b0;
    mgmt_reg   = REG_CTRL;
    mgmt_wdata = '0;
    unique case (state)
      S_SCAN, S_POLL_PRE, S_POLL_POST, S_FALLBACK: ;
      S_RST_WR:   begin mgmt_wr = 1'b1; mgmt_wdata = r0_q | (D_W'(1) << B_RESET); end
      S_AN_OFF:   mgmt_wr = 1'b1;
      S_DOWN_WR:  begin mgmt_wr = 1'b1; mgmt_wdata = D_W'(res_sp) << B_SEL_HI; end
      S_AN_POLL:  mgmt_reg = REG_STAT;
      S_RD_ADV1G: mgmt_reg = REG_ADV1G;
      S_RD_LP1G:  mgmt_reg = REG_LP1G;
      S_RD_ADV:   mgmt_reg = REG_ADV;
      S_RD_LP:    mgmt_reg = REG_LP;
      default:    mgmt_req = 1'b0;
    endcase
    mgmt_phy = (state == S_SCAN) ? scan_idx : phy_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      scan_idx  <= '0;
      phy_addr  <= '0;
      r0_q      <= '0;
      adv1g_q   <= '0;
      lp1g_q    <= '0;
      adv_q     <= '0;
      lp_q      <= '0;
      have_low  <= 1'b0;
      res_gb    <= 1'b0;
      res_sp    <= 1'b0;
      res_fd    <= 1'b0;
      mode_gbit <= 1'b0;
      mode_100  <= 1'b0;
      mode_full <= 1'b0;
      link_done <= 1'b0;
      link_fail <= 1'b0;
    end else begin
      link_done <= 1'b0;
      link_fail <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          {mode_gbit, mode_100, mode_full} <= '0;
          {res_gb, res_sp, res_fd} <= '0;
          {adv1g_q, lp1g_q, adv_q, lp_q} <= '0;
          have_low <= 1'b0;
          scan_idx <= '0;
          phy_addr <= default_addr;
          state    <= scan_en ? S_SCAN : S_POLL_PRE;
        end
        S_SCAN: if (mgmt_ack) begin
          if (d != '0 && d != {D_W{1'b1}}) begin
            phy_addr <= scan_idx;
            state    <= S_POLL_PRE;
          end else if (scan_idx == LAST_ADDR) begin
            state <= S_POLL_PRE;
          end else begin
            scan_idx <= scan_idx + 1'b1;
          end
        end
        S_POLL_PRE: if (mgmt_ack) begin
          if (!d[B_RESET]) begin
            r0_q  <= d;
            state <= S_RST_WR;
          end else if (expired) begin
            state <= S_FAIL;
          end
        end
        S_RST_WR: if (mgmt_ack) state <= S_POLL_POST;
        S_POLL_POST: if (mgmt_ack) begin
          if (!d[B_RESET]) state <= d[B_AN_EN] ? S_AN_POLL : S_AN_OFF;
          else if (expired) state <= S_FAIL;
        end
        S_AN_OFF: if (mgmt_ack) state <= S_FINISH;
        S_AN_POLL: if (mgmt_ack) begin
          if (d[B_AN_DONE]) state <= d[B_EXT_ST] ? S_RD_ADV1G : S_RD_ADV;
          else if (expired) state <= S_FALLBACK;
        end
        S_FALLBACK: if (mgmt_ack) begin
          res_gb <= d[B_SEL_LO] && !d[B_SEL_HI];
          res_sp <= !d[B_SEL_LO] && d[B_SEL_HI];
          res_fd <= d[B_DUPLEX];
          state  <= S_FINISH;
        end
        S_RD_ADV1G: if (mgmt_ack) begin adv1g_q <= d[9:8];  state <= S_RD_LP1G; end
        S_RD_LP1G:  if (mgmt_ack) begin lp1g_q  <= d[11:10]; state <= S_DECIDE; end
        S_RD_ADV:   if (mgmt_ack) begin adv_q   <= d[8:6];  state <= S_RD_LP; end
        S_RD_LP: if (mgmt_ack) begin
          lp_q     <= d[8:6];
          have_low <= 1'b1;
          state    <= S_DECIDE;
        end
        S_DECIDE: begin
          if (!have_low && need_low) begin
            state <= S_RD_ADV;
          end else begin
            res_gb <= rs_gb;
            res_sp <= rs_sp;
            res_fd <= rs_fd;
            state  <= downgrade ? S_DOWN_WR : S_FINISH;
          end
        end
        S_DOWN_WR: if (mgmt_ack) state <= S_FINISH;
        S_FINISH: begin
          mode_gbit <= res_gb;
          mode_100  <= res_sp;
          mode_full <= res_fd;
          link_done <= 1'b1;
          state     <= S_IDLE;
        end
        S_FAIL: begin
          link_fail <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        mgmt_req,
  input logic        mgmt_wr,
  input logic [4:0]  mgmt_phy,
  input logic [4:0]  mgmt_reg,
  input logic [15:0] mgmt_wdata,
  input logic        mgmt_ack,
  input logic        mode_gbit,
  input logic        mode_100,
  input logic        mode_full,
  input logic        link_done,
  input logic        link_fail
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    mgmt_req && !mgmt_ack |=> mgmt_req && $stable(mgmt_wr) && $stable(mgmt_reg)
                              && $stable(mgmt_phy) && $stable(mgmt_wdata));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    link_done |=> !link_done);

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !start |=> link_done || $stable({mode_gbit, mode_100, mode_full}));

  a_r10_speed_excl: assert property (@(posedge clk) disable iff (rst)
    link_done |-> !(mode_gbit && mode_100));

  a_r3_fail_clean: assert property (@(posedge clk) disable iff (rst)
    link_fail |-> !link_done && !mode_gbit && !mode_100 && !mode_full);

  a_r2_write_ctrl_only: assert property (@(posedge clk) disable iff (rst)
    mgmt_req && mgmt_wr |-> mgmt_reg == 5'd0);
endmodule

bind phy_link_seq phy_link_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .mgmt_req(mgmt_req), .mgmt_wr(mgmt_wr),
  .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
  .mgmt_ack(mgmt_ack), .mode_gbit(mode_gbit), .mode_100(mode_100),
  .mode_full(mode_full), .link_done(link_done), .link_fail(link_fail)
);

// File: tb/phy_link_seq_tb.sv
module phy_link_seq_tb;
  localparam int CLK_HZ = 10000;  // 10 cycles per ms
  localparam int TO_MS  = 20;     // 200-cycle window

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, scan_en = 1'b0, mac_gbit_ok = 1'b1;
  logic [4:0]  default_addr = 5'd3;
  logic        mgmt_req, mgmt_wr, mgmt_ack, mgmt_rinv;
  logic [4:0]  mgmt_phy, mgmt_reg, phy_addr;
  logic [15:0] mgmt_wdata, mgmt_rdata;
  logic        mode_gbit, mode_100, mode_full, link_done, link_fail;

  always #5 clk = ~clk;

  phy_link_seq #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TO_MS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .scan_en(scan_en),
    .default_addr(default_addr), .mac_gbit_ok(mac_gbit_ok),
    .mgmt_req(mgmt_req), .mgmt_wr(mgmt_wr), .mgmt_phy(mgmt_phy),
    .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata), .mgmt_ack(mgmt_ack),
    .mgmt_rdata(mgmt_rdata), .mgmt_rinv(mgmt_rinv), .phy_addr(phy_addr),
    .mode_gbit(mode_gbit), .mode_100(mode_100), .mode_full(mode_full),
    .link_done(link_done), .link_fail(link_fail)
  );

  int nchk = 0, nerr = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural PHY on the management port ----------------
  int          present_at;
  int          absent_kind[32];   // 0 invalid, 1 reads 0x0000, 2 reads 0xFFFF
  logic [15:0] r0_base, r1_base, r4v, r5v, r9v, r10v;
  int          busy_left, busy_after, an_left, lat;

  always @(posedge clk) begin
    if (rst) begin
      mgmt_ack <= 1'b0; mgmt_rdata <= '0; mgmt_rinv <= 1'b0; lat = 0;
    end else if (mgmt_ack) begin
      mgmt_ack <= 1'b0;
    end else if (mgmt_req) begin
      if (lat == 2) begin
        lat = 0;
        mgmt_ack   <= 1'b1;
        mgmt_rinv  <= 1'b0;
        mgmt_rdata <= 16'h0000;
        if (int'(mgmt_phy) != present_at) begin
          if (!mgmt_wr) begin
            if (absent_kind[mgmt_phy] == 0) mgmt_rinv <= 1'b1;
            else if (absent_kind[mgmt_phy] == 2) mgmt_rdata <= 16'hFFFF;
          end
        end else if (mgmt_wr) begin
          if (mgmt_reg == 5'd0) begin
            if (mgmt_wdata[15]) begin r0_base = mgmt_wdata & 16'h7FFF; busy_left = busy_after; end
            else r0_base = mgmt_wdata;
          end
        end else begin
          case (mgmt_reg)
            5'd0: begin
              mgmt_rdata <= r0_base | ((busy_left > 0) ? 16'h8000 : 16'h0);
              if (busy_left > 0) busy_left--;
            end
            5'd1: begin
              if (an_left == 0) mgmt_rdata <= r1_base | 16'h0020;
              else begin
                mgmt_rdata <= r1_base & ~16'h0020;
                if (an_left > 0) an_left--;
              end
            end
            5'd4:  mgmt_rdata <= r4v;
            5'd5:  mgmt_rdata <= r5v;
            5'd9:  mgmt_rdata <= r9v;
            5'd10: mgmt_rdata <= r10v;
            default: mgmt_rdata <= 16'h0;
          endcase
        end
      end else lat++;
    end
  end

  // ---------------- reference model: access order and flags ----------------
  logic [27:0] expq[$];           // {poll, wr, phy, reg, data}
  logic [27:0] last_item;
  bit          have_last = 0;
  logic [2:0]  mdl_flags = 3'b000, exp_final = 3'b000;
  bit          prev_done = 0;
  int          cyc = 0;

  function automatic string tag_of(logic [4:0] r);
    if (r == 5'd1) return "R5";
    if (r == 5'd9 || r == 5'd10) return "R6";
    if (r == 5'd4 || r == 5'd5) return "R7";
    return "R2";
  endfunction

  always @(negedge clk) begin
    logic [26:0] seen;
    if (!rst) begin
      cyc++;
      if (mgmt_req && mgmt_ack) begin
        seen = {mgmt_wr, mgmt_phy, mgmt_reg, mgmt_wr ? mgmt_wdata : 16'h0};
        if (expq.size() > 0 && seen == expq[0][26:0]) begin
          last_item = expq.pop_front(); have_last = 1;
          chk(1, "R2", "access", 0, 0);
        end else if (have_last && last_item[27] && seen == last_item[26:0]) begin
          chk(1, "R2", "poll repeat", 0, 0);
        end else begin
          chk(0, tag_of(mgmt_reg), "access {wr,phy,reg,data}", int'(seen),
              expq.size() > 0 ? int'(expq[0][26:0]) : -1);
        end
      end
      if (link_done) begin
        chk({mode_gbit, mode_100, mode_full} == exp_final, "R10", "flags at done",
            {mode_gbit, mode_100, mode_full}, exp_final);
        mdl_flags = exp_final;
        chk(!prev_done, "R10", "done longer than one cycle", 1, 0);
      end else begin
        chk({mode_gbit, mode_100, mode_full} == mdl_flags, "R10", "flags hold",
            {mode_gbit, mode_100, mode_full}, mdl_flags);
      end
      if (link_fail)
        chk({mode_gbit, mode_100, mode_full} == 3'b000, "R3", "flags at fail",
            {mode_gbit, mode_100, mode_full}, 0);
      prev_done = link_done;
      if (start) mdl_flags = 3'b000;
    end
  end

  task automatic q_rd(bit poll, int a, int r);
    expq.push_back({poll, 1'b0, 5'(a), 5'(r), 16'h0});
  endtask
  task automatic q_wr(int a, int r, logic [15:0] dv);
    expq.push_back({1'b0, 1'b1, 5'(a), 5'(r), dv});
  endtask

  task automatic phy_cfg(int at, logic [15:0] r0, int b0, int b1, logic [15:0] r1, int an,
                         logic [15:0] a4, logic [15:0] a5, logic [15:0] a9, logic [15:0] a10);
    present_at = at; r0_base = r0; busy_left = b0; busy_after = b1;
    r1_base = r1; an_left = an; r4v = a4; r5v = a5; r9v = a9; r10v = a10;
    for (int i = 0; i < 32; i++) absent_kind[i] = 0;
  endtask

  task automatic run_case(string tag, bit sc, logic [4:0] dflt, bit mac,
                          logic [2:0] flags, bit exp_fail, logic [4:0] exp_addr,
                          output int elapsed);
    int t0;
    bit got_done, got_fail;
    got_done = 0; got_fail = 0;
    @(posedge clk); #1;
    scan_en = sc; default_addr = dflt; mac_gbit_ok = mac; exp_final = flags;
    start = 1'b1; t0 = cyc;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (link_done) got_done = 1;
      if (link_fail) got_fail = 1;
      if (got_done || got_fail) break;
    end
    elapsed = cyc - t0;
    chk(got_done == !exp_fail && got_fail == exp_fail, tag, "end pulse {done,fail}",
        {got_done, got_fail}, {!exp_fail, exp_fail});
    chk(phy_addr == exp_addr, "R1", "selected address", phy_addr, exp_addr);
    chk(expq.size() == 0, tag, "expected accesses left over", expq.size(), 0);
    expq.delete(); have_last = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run hung");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int el;
    phy_cfg(-1, 16'h0, 0, 0, 16'h0, 0, 16'h0, 16'h0, 16'h0, 16'h0);
    repeat (4) @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk(!mgmt_req && !link_done && !link_fail, "R1", "reset state req/done/fail",
        {mgmt_req, link_done, link_fail}, 0);
    chk({mode_gbit, mode_100, mode_full} == 3'b000, "R1", "reset flags",
        {mode_gbit, mode_100, mode_full}, 0);

    // R6: gigabit full, MAC capable, registers 4/5 skipped
    phy_cfg(3, 16'h1000, 1, 2, 16'h0100, 2, 16'h0, 16'h0, 16'h0200, 16'h0800);
    q_rd(1, 3, 0); q_wr(3, 0, 16'h9000); q_rd(1, 3, 0); q_rd(1, 3, 1);
    q_rd(0, 3, 9); q_rd(0, 3, 10);
    run_case("R6", 0, 5'd3, 1, 3'b101, 0, 5'd3, el);

    // R8: gigabit resolved but MAC not capable -> downgrade write 0x2000
    phy_cfg(3, 16'h1000, 0, 1, 16'h0100, 1, 16'h0180, 16'h0180, 16'h0200, 16'h0800);
    q_rd(1, 3, 0); q_wr(3, 0, 16'h9000); q_rd(1, 3, 0); q_rd(1, 3, 1);
    q_rd(0, 3, 9); q_rd(0, 3, 10); q_rd(0, 3, 4); q_rd(0, 3, 5); q_wr(3, 0, 16'h2000);
    run_case("R8", 0, 5'd3, 0, 3'b010, 0, 5'd3, el);

    // R1 + R9 + R7: scan skips 0x0000, invalid, 0xFFFF; 100F,100H,10F order
    phy_cfg(4, 16'h1000, 1, 1, 16'h0000, 1, 16'h01C0, 16'h01C0, 16'h0, 16'h0);
    absent_kind[0] = 1; absent_kind[1] = 0; absent_kind[2] = 2; absent_kind[3] = 0;
    for (int a = 0; a <= 4; a++) q_rd(0, a, 0);
    q_rd(1, 4, 0); q_wr(4, 0, 16'h9000); q_rd(1, 4, 0); q_rd(1, 4, 1);
    q_rd(0, 4, 4); q_rd(0, 4, 5);
    run_case("R7", 1, 5'd9, 1, 3'b011, 0, 5'd4, el);

    // R7: only 100 half common
    phy_cfg(3, 16'h1000, 0, 0, 16'h0000, 0, 16'h00C0, 16'h0080, 16'h0, 16'h0);
    q_rd(1, 3, 0); q_wr(3, 0, 16'h9000); q_rd(1, 3, 0); q_rd(1, 3, 1);
    q_rd(0, 3, 4); q_rd(0, 3, 5);
    run_case("R7", 0, 5'd3, 1, 3'b010, 0, 5'd3, el);

    // R4: autonegotiation disabled
    phy_cfg(3, 16'h0000, 0, 1, 16'h0, 0, 16'h0, 16'h0, 16'h0, 16'h0);
    q_rd(1, 3, 0); q_wr(3, 0, 16'h8000); q_rd(1, 3, 0); q_wr(3, 0, 16'h0000);
    run_case("R4", 0, 5'd3, 1, 3'b000, 0, 5'd3, el);

    // R5: negotiation never completes -> fallback from register 0
    phy_cfg(3, 16'h1140, 0, 0, 16'h0100, -1, 16'h0, 16'h0, 16'h0, 16'h0);
    q_rd(1, 3, 0); q_wr(3, 0, 16'h9140); q_rd(1, 3, 0); q_rd(1, 3, 1); q_rd(0, 3, 0);
    run_case("R5", 0, 5'd3, 1, 3'b101, 0, 5'd3, el);
    chk(el >= 200, "R5", "fallback before window expired", el, 200);

    // R5: fallback selecting 100M half
    phy_cfg(3, 16'h3000, 0, 0, 16'h0000, -1, 16'h0, 16'h0, 16'h0, 16'h0);
    q_rd(1, 3, 0); q_wr(3, 0, 16'hB000); q_rd(1, 3, 0); q_rd(1, 3, 1); q_rd(0, 3, 0);
    run_case("R5", 0, 5'd3, 1, 3'b010, 0, 5'd3, el);

    // R3: reset bit stuck -> fail near end of window
    phy_cfg(3, 16'h1000, 100000, 0, 16'h0, 0, 16'h0, 16'h0, 16'h0, 16'h0);
    q_rd(1, 3, 0);
    run_case("R3", 0, 5'd3, 1, 3'b000, 1, 5'd3, el);
    chk(el >= 195 && el <= 225, "R3", "fail timing in cycles", el, 205);

    // R9 + R1: scan finds nothing (all invalid) -> default, invalid reads look busy -> fail
    phy_cfg(-1, 16'h0, 0, 0, 16'h0, 0, 16'h0, 16'h0, 16'h0, 16'h0);
    for (int a = 0; a < 32; a++) q_rd(0, a, 0);
    q_rd(1, 6, 0);
    run_case("R9", 1, 5'd6, 1, 3'b000, 1, 5'd6, el);

    // R6: both gigabit modes common -> half wins (later match)
    phy_cfg(3, 16'h1000, 0, 0, 16'h0100, 0, 16'h0, 16'h0, 16'h0300, 16'h0C00);
    q_rd(1, 3, 0); q_wr(3, 0, 16'h9000); q_rd(1, 3, 0); q_rd(1, 3, 1);
    q_rd(0, 3, 9); q_rd(0, 3, 10);
    run_case("R6", 0, 5'd3, 1, 3'b100, 0, 5'd3, el);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule